// File: doc/BRIEF.md
# Partial-Word Load/Store Alignment Unit

This block is the purely combinational formatting stage between a 32-bit register file and a memory port that is one word wide. For loads it takes the word read from memory and produces the value to write back into the destination register. Byte and halfword loads pick the addressed lane and then sign-extend or zero-extend it. Word loads pass the word through. The left and right unaligned loads merge memory bytes into the register's old contents, according to the low two address bits.

For stores it takes the register value and produces the word to drive onto the memory port, together with a four-bit byte-enable mask. Byte and halfword stores repeat the source data in every lane and enable only the addressed lanes. The left and right unaligned stores merge register bytes into the memory word that has already been read, and write the whole aligned word. The unit also flags misaligned halfword and word accesses. It always presents the word-aligned address to the memory port.

The caller sequences the bus read that comes before a partial store. The caller also acts on the error flag.

Top module: `lsalign_top`

## Requirements
- R1: Op 1 is the signed byte load and op 2 is the unsigned byte load. The byte at address offset k sits in bits 8k+7..8k of the memory word. The signed load copies that byte's bit 7 into result bits 31..8. The unsigned load clears result bits 31..8.
- R2: Op 3 is the signed halfword load and op 4 is the unsigned halfword load. The halfword is bits 15..0 of the memory word when address bit 1 is 0, and bits 31..16 when it is 1. The signed load copies the halfword's bit 15 into bits 31..16. The unsigned load clears bits 31..16.
- R3: The error flag rises for ops 3, 4 and 9 when address bit 0 is set. It rises for ops 5 and 10 when either of the low two address bits is set. No other op raises it. While the flag is high, the load result, the store word and the byte enables are all zero.
- R4: Op 5 (aligned word load) returns the memory word unchanged.
- R5: Op 6 is the left merge load, with k the low two address bits. k=0 returns the memory word. For k=1, 2 or 3 it keeps the low 1, 2 or 3 bytes of the old register value and fills the upper bytes with the memory word shifted left by 8k.
- R6: Op 7 is the right merge load, with k the low two address bits. k=3 returns the memory word. For k=0, 1 or 2 it keeps the top 3, 2 or 1 bytes of the old register value. The low k+1 bytes come from the top k+1 bytes of the memory word.
- R7: Op 11 is the left merge store, with k the low two address bits. It writes the register value shifted right by 8k. The top k bytes of the memory word are kept, and all four byte enables are set.
- R8: Op 12 is the right merge store, with k the low two address bits. It writes the register value shifted left by 8(3-k). The low 3-k bytes of the memory word are kept, and all four byte enables are set.
- R9: Op 8 stores a byte: the register's low byte is repeated in all four lanes and only enable bit k is set. Op 9 stores a halfword: the register's low halfword is repeated in both halves, and enables 0011 or 1100 are set according to address bit 1. Op 10 stores a word: the register value is written with enables 1111.
- R10: The memory address output equals the input address with its low two bits cleared, for every op.
- R11: Ops 0, 13, 14 and 15 are no-ops: all outputs except the address are zero. Load ops drive zero store data and zero enables. Store ops drive a zero load result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see requirements) |
| addr_i | input | ADDR_W | Effective byte address |
| mem_rdata_i | input | 32 | Word read from memory at the aligned address |
| reg_val_i | input | 32 | Register value: store source, or old destination for merge loads |
| load_data_o | output | 32 | Value to write into the destination register |
| store_data_o | output | 32 | Word to drive onto the memory write port |
| store_be_o | output | 4 | Byte enables for the memory write |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| addr_err_o | output | 1 | Misaligned halfword or word access |

## Verification
Alignment checking and lane formatting act in the same evaluation: a misaligned halfword or word access produces a formatted result and must also be suppressed. The sweep drives every op code at all four low-address offsets, with each data pattern. So every misaligned halfword or word access meets the formatter with live data, and the bench expects all-zero outputs with the flag raised. The same sweep applies the same patterns at aligned offsets, where the flag must stay low and the byte-model result must appear. This separates an error check that is too broad from one that leaks data.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_LDB  = 4'd1,
    OP_LDBU = 4'd2,
    OP_LDH  = 4'd3,
    OP_LDHU = 4'd4,
    OP_LDW  = 4'd5,
    OP_LDL  = 4'd6,
    OP_LDR  = 4'd7,
    OP_STB  = 4'd8,
    OP_STH  = 4'd9,
    OP_STW  = 4'd10,
    OP_STL  = 4'd11,
    OP_STR  = 4'd12
  } lsa_op_e;

  function automatic logic [BYTE_W-1:0] pick_lane(input logic [WORD_W-1:0] w,
                                                  input logic [OFF_W-1:0] k);
    logic [WORD_W-1:0] sh;
    sh = w >> (BYTE_W * k);
    return sh[BYTE_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] ext_byte(input logic [BYTE_W-1:0] b,
                                                 input logic sgn);
    return {{(WORD_W-BYTE_W){sgn & b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic [WORD_W-1:0] ext_half(input logic [2*BYTE_W-1:0] h,
                                                 input logic sgn);
    return {{(WORD_W-2*BYTE_W){sgn & h[2*BYTE_W-1]}}, h};
  endfunction

  // merge memory into the upper part of the old register
  function automatic logic [WORD_W-1:0] merge_load_left(input logic [WORD_W-1:0] old,
                                                        input logic [WORD_W-1:0] mem,
                                                        input logic [OFF_W-1:0] k);
    case (k)
      2'd0:    return mem;
      2'd1:    return {mem[23:0], old[7:0]};
      2'd2:    return {mem[15:0], old[15:0]};
      default: return {mem[7:0],  old[23:0]};
    endcase
  endfunction

  // merge the top of memory into the lower part of the old register
  function automatic logic [WORD_W-1:0] merge_load_right(input logic [WORD_W-1:0] old,
                                                         input logic [WORD_W-1:0] mem,
                                                         input logic [OFF_W-1:0] k);
    case (k)
      2'd0:    return {old[31:8],  mem[31:24]};
      2'd1:    return {old[31:16], mem[31:16]};
      2'd2:    return {old[31:24], mem[31:8]};
      default: return mem;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] merge_store_left(input logic [WORD_W-1:0] mem,
                                                         input logic [WORD_W-1:0] rv,
                                                         input logic [OFF_W-1:0] k);
    case (k)
      2'd0:    return rv;
      2'd1:    return {mem[31:24], rv[31:8]};
      2'd2:    return {mem[31:16], rv[31:16]};
      default: return {mem[31:8],  rv[31:24]};
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] merge_store_right(input logic [WORD_W-1:0] mem,
                                                          input logic [WORD_W-1:0] rv,
                                                          input logic [OFF_W-1:0] k);
    case (k)
      2'd0:    return {rv[7:0],  mem[23:0]};
      2'd1:    return {rv[15:0], mem[15:0]};
      2'd2:    return {rv[23:0], mem[7:0]};
      default: return rv;
    endcase
  endfunction
endpackage

// File: rtl/lsa_addr_chk.sv
`timescale 1ns/1ps
module lsa_addr_chk
  import lsa_pkg::*;
(
  input  lsa_op_e          op,
  input  logic [OFF_W-1:0] off,
  output logic             half_misal,
  output logic             word_misal,
  output logic             err
);
  logic is_half, is_word;

  always_comb begin
    is_half = (op == OP_LDH) || (op == OP_LDHU) || (op == OP_STH);
    is_word = (op == OP_LDW) || (op == OP_STW);
  end

  assign half_misal = is_half & off[0];
  assign word_misal = is_word & (off != '0);
  assign err        = half_misal | word_misal;
endmodule

// File: rtl/lsa_load_fmt.sv
`timescale 1ns/1ps
module lsa_load_fmt
  import lsa_pkg::*;
(
  input  lsa_op_e           op,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] mem,
  input  logic [WORD_W-1:0] old,
  output logic [WORD_W-1:0] data,
  output logic              is_load
);
  logic [BYTE_W-1:0]   lane_b;
  logic [2*BYTE_W-1:0] lane_h;

  assign lane_b = pick_lane(mem, off);
  assign lane_h = off[1] ? mem[WORD_W-1:2*BYTE_W] : mem[2*BYTE_W-1:0];

  always_comb begin
    is_load = 1'b1;
    case (op)
      OP_LDB:  data = ext_byte(lane_b, 1'b1);
      OP_LDBU: data = ext_byte(lane_b, 1'b0);
      OP_LDH:  data = ext_half(lane_h, 1'b1);
      OP_LDHU: data = ext_half(lane_h, 1'b0);
      OP_LDW:  data = mem;
      OP_LDL:  data = merge_load_left(old, mem, off);
      OP_LDR:  data = merge_load_right(old, mem, off);
      default: begin
        data    = '0;
        is_load = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lsa_store_fmt.sv
`timescale 1ns/1ps
module lsa_store_fmt
  import lsa_pkg::*;
(
  input  lsa_op_e           op,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] mem,
  input  logic [WORD_W-1:0] rv,
  output logic [WORD_W-1:0] data,
  output logic [LANES-1:0]  be,
  output logic              is_store
);
  logic [WORD_W-1:0] byte_rep;
  logic [WORD_W-1:0] half_rep;
  logic [LANES-1:0]  be_byte;
  logic [LANES-1:0]  be_half;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byte_rep[g*BYTE_W +: BYTE_W] = rv[BYTE_W-1:0];
    assign be_byte[g] = (off == OFF_W'(g));
    assign be_half[g] = (off[1] == g[1]);
  end

  for (genvar h = 0; h < LANES/2; h++) begin : g_half
    assign half_rep[h*2*BYTE_W +: 2*BYTE_W] = rv[2*BYTE_W-1:0];
  end

  always_comb begin
    is_store = 1'b1;
    case (op)
      OP_STB: begin data = byte_rep; be = be_byte; end
      OP_STH: begin data = half_rep; be = be_half; end
      OP_STW: begin data = rv;       be = '1;      end
      OP_STL: begin data = merge_store_left(mem, rv, off);  be = '1; end
      OP_STR: begin data = merge_store_right(mem, rv, off); be = '1; end
      default: begin
        data     = '0;
        be       = '0;
        is_store = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lsalign_top.sv
`timescale 1ns/1ps
module lsalign_top
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic [31:0]       reg_val_i,
  output logic [31:0]       load_data_o,
  output logic [31:0]       store_data_o,
  output logic [3:0]        store_be_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              addr_err_o
);
  lsa_op_e           op;
  logic [OFF_W-1:0]  off;
  logic              half_misal;
  logic              word_misal;
  logic              err;
  logic              is_load;
  logic              is_store;
  logic [WORD_W-1:0] ld_raw;
  logic [WORD_W-1:0] st_raw;
  logic [LANES-1:0]  be_raw;

  assign op  = lsa_op_e'(op_i);
  assign off = addr_i[OFF_W-1:0];

  lsa_addr_chk u_chk_addr (
    .op(op), .off(off), .half_misal(half_misal),
    .word_misal(word_misal), .err(err)
  );

  lsa_load_fmt u_load (
    .op(op), .off(off), .mem(mem_rdata_i), .old(reg_val_i),
    .data(ld_raw), .is_load(is_load)
  );

  lsa_store_fmt u_store (
    .op(op), .off(off), .mem(mem_rdata_i), .rv(reg_val_i),
    .data(st_raw), .be(be_raw), .is_store(is_store)
  );

  assign load_data_o  = err ? '0 : ld_raw;
  assign store_data_o = err ? '0 : st_raw;
  assign store_be_o   = err ? '0 : be_raw;
  assign addr_err_o   = err;
  assign mem_addr_o   = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/lsa_checker.sv
`timescale 1ns/1ps
module lsa_checker #(
  parameter int ADDR_W = 32
)(
  input logic [3:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       load_data_o,
  input logic [31:0]       store_data_o,
  input logic [3:0]        store_be_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              addr_err_o,
  input logic              is_load,
  input logic              is_store,
  input logic              half_misal,
  input logic              word_misal
);
  always_comb begin
    assert_lbu_clear_R1: assert (!(op_i == 4'd2 && !addr_err_o) || load_data_o[31:8] == 24'd0)
      else $error("R1 unsigned byte upper bits");
    assert_lb_ext_R1: assert (!(op_i == 4'd1) || load_data_o[31:8] == {24{load_data_o[7]}})
      else $error("R1 signed byte extension");
    assert_lhu_clear_R2: assert (!(op_i == 4'd4) || load_data_o[31:16] == 16'd0)
      else $error("R2 unsigned half upper bits");
    assert_err_quiet_R3: assert (!addr_err_o || (store_be_o == 4'd0 && load_data_o == 32'd0
                                                 && store_data_o == 32'd0))
      else $error("R3 outputs not suppressed");
    assert_err_src_R3: assert (addr_err_o == (half_misal | word_misal))
      else $error("R3 error source");
    assert_sb_onehot_R9: assert (!(op_i == 4'd8) || $countones(store_be_o) == 1)
      else $error("R9 byte enable count");
    assert_sh_pair_R9: assert (!(op_i == 4'd9 && !addr_err_o) || $countones(store_be_o) == 2)
      else $error("R9 half enable count");
    assert_aligned_R10: assert (mem_addr_o[1:0] == 2'b00 && mem_addr_o[ADDR_W-1:2] == addr_i[ADDR_W-1:2])
      else $error("R10 address not aligned");
    assert_class_R11: assert (!(is_load && is_store))
      else $error("R11 op in both classes");
    assert_load_no_be_R11: assert (!is_load || store_be_o == 4'd0)
      else $error("R11 load drove enables");
    assert_store_no_ld_R11: assert (!is_store || load_data_o == 32'd0)
      else $error("R11 store drove load data");
  end
endmodule

bind lsalign_top lsa_checker #(.ADDR_W(ADDR_W)) u_lsa_checker (
  .op_i(op_i), .addr_i(addr_i), .load_data_o(load_data_o),
  .store_data_o(store_data_o), .store_be_o(store_be_o),
  .mem_addr_o(mem_addr_o), .addr_err_o(addr_err_o),
  .is_load(is_load), .is_store(is_store),
  .half_misal(half_misal), .word_misal(word_misal)
);

// File: tb/sim_lsalign_top.sv
`timescale 1ns/1ps
module sim_lsalign_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op;
  logic [31:0] addr, mem, rv;
  logic [31:0] ld, st, maddr;
  logic [3:0]  be;
  logic        err;
  int          total = 0;
  int          bad   = 0;

  always #4 clk = ~clk;

  lsalign_top u0 (
    .op_i(op), .addr_i(addr), .mem_rdata_i(mem), .reg_val_i(rv),
    .load_data_o(ld), .store_data_o(st), .store_be_o(be),
    .mem_addr_o(maddr), .addr_err_o(err)
  );

  function automatic logic [7:0] bt(input logic [31:0] w, input int i);
    return w[8*i +: 8];
  endfunction

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8080_8080;
      3: return 32'h7F7F_7F7F;
      4: return 32'h0123_4567;
      5: return 32'hFEDC_BA98;
      default: return (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endcase
  endfunction

  function automatic string tag(input int o);
    case (o)
      1, 2:    return "R1";
      3, 4:    return "R2";
      5:       return "R4";
      6:       return "R5";
      7:       return "R6";
      11:      return "R7";
      12:      return "R8";
      8, 9, 10: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string r, input string what, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s op=%0d addr=%h actual=%h expected=%h", r, what, op, addr, a, e);
    end
  endtask

  task automatic model(input int o, input logic [31:0] ad, input logic [31:0] m,
                       input logic [31:0] r, output logic [31:0] eld,
                       output logic [31:0] est, output logic [3:0] ebe, output logic eer);
    int k;
    k = int'(ad[1:0]);
    eld = '0; est = '0; ebe = '0;
    eer = ((o == 3 || o == 4 || o == 9) && ad[0]) || ((o == 5 || o == 10) && k != 0);
    case (o)
      1, 2: begin
        eld[7:0] = bt(m, k);
        if (o == 1 && eld[7]) eld[31:8] = '1;
      end
      3, 4: begin
        eld[15:0] = ad[1] ? m[31:16] : m[15:0];
        if (o == 3 && eld[15]) eld[31:16] = '1;
      end
      5: eld = m;
      6: for (int i = 0; i < 4; i++) eld[8*i +: 8] = (i < k) ? bt(r, i) : bt(m, i - k);
      7: for (int i = 0; i < 4; i++) eld[8*i +: 8] = (i <= k) ? bt(m, i + 3 - k) : bt(r, i);
      8: begin
        for (int i = 0; i < 4; i++) est[8*i +: 8] = r[7:0];
        ebe[k] = 1'b1;
      end
      9: begin
        est = {r[15:0], r[15:0]};
        ebe = ad[1] ? 4'b1100 : 4'b0011;
      end
      10: begin est = r; ebe = 4'hF; end
      11: begin
        for (int i = 0; i < 4; i++) est[8*i +: 8] = (i < 4 - k) ? bt(r, i + k) : bt(m, i);
        ebe = 4'hF;
      end
      12: begin
        for (int i = 0; i < 4; i++) est[8*i +: 8] = (i >= 3 - k) ? bt(r, i - (3 - k)) : bt(m, i);
        ebe = 4'hF;
      end
      default: ;
    endcase
    if (eer) begin eld = '0; est = '0; ebe = '0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] eld, est;
    logic [3:0]  ebe;
    logic        eer;
    op = 4'd0; addr = 32'h1234_5677; mem = 32'hDEAD_BEEF; rv = 32'hCAFE_F00D;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset-state / idle op: R11 and R10
    chk("R11", "idle load", ld, 32'd0);
    chk("R11", "idle store", st, 32'd0);
    chk("R11", "idle be", {28'd0, be}, 32'd0);
    chk("R11", "idle err", {31'd0, err}, 32'd0);
    chk("R10", "idle addr", maddr, 32'h1234_5674);

    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 4; k++) begin
        for (int d = 0; d < 12; d++) begin
          @(negedge clk);
          op   = 4'(o);
          addr = (pat(d + 3) & 32'hFFFF_FFFC) | 32'(k);
          mem  = pat(d);
          rv   = pat(d + 6);
          #2;
          model(o, addr, mem, rv, eld, est, ebe, eer);
          chk(eer ? "R3" : tag(o), "load", ld, eld);
          chk(eer ? "R3" : tag(o), "store", st, est);
          chk(eer ? "R3" : tag(o), "be", {28'd0, be}, {28'd0, ebe});
          chk("R3", "err", {31'd0, err}, {31'd0, eer});
          chk("R10", "addr", maddr, {addr[31:2], 2'b00});
        end
      end
    end

    // directed corners
    @(negedge clk); op = 4'd1; addr = 32'd3; mem = 32'h80_00_00_00; rv = 32'd0; #2;
    chk("R1", "lb top lane", ld, 32'hFFFF_FF80);
    @(negedge clk); op = 4'd4; addr = 32'd2; mem = 32'hF00D_1234; #2;
    chk("R2", "lhu upper", ld, 32'h0000_F00D);
    @(negedge clk); op = 4'd6; addr = 32'd2; mem = 32'hAABB_CCDD; rv = 32'h1122_3344; #2;
    chk("R5", "left load k2", ld, 32'hCCDD_3344);
    @(negedge clk); op = 4'd7; addr = 32'd1; #2;
    chk("R6", "right load k1", ld, 32'h1122_AABB);
    @(negedge clk); op = 4'd11; addr = 32'd1; #2;
    chk("R7", "left store k1", st, 32'hAA11_2233);
    @(negedge clk); op = 4'd12; addr = 32'd2; #2;
    chk("R8", "right store k2", st, 32'h2233_44DD);
    @(negedge clk); op = 4'd10; addr = 32'd2; #2;
    chk("R3", "sw misaligned be", {28'd0, be}, 32'd0);
    chk("R3", "sw misaligned err", {31'd0, err}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule